// File: doc/BRIEF.md
# Width-Masked Paged Memory Map

This block decodes the address bus of a 16-bit processor and models the storage behind it. The address space is cut into fixed-size pages selected by the upper address bits. Each page has a kind (unmapped, RAM or ROM) and a storage width of 8, 10, 12, 14 or 16 bits. Reads return only the low bits that the page's width allows. Writes to RAM pages keep only those bits. Unmapped pages read as all ones and drop writes. ROM pages drop processor writes and are filled through a configuration port, which also sets the kind and width of each page.

Only the lowest `BACKED_PAGES` pages have storage behind them. A RAM or ROM kind can be given to those pages only; every other page stays unmapped.

The page table is a plain array with no reset on its entries. After reset a two-state machine wipes it. In `ST_CLEAR` one entry is cleared per cycle, every lookup reads as unmapped, and configuration commands are refused. Once the last entry is cleared it moves to `ST_RUN` (the transition "sweep done") and stays there until the next reset, which is the only transition back to `ST_CLEAR`.

Top module: `paged_mem_map`

## Requirements
- R1: While `rst_n` is low, and for `NUM_PAGES` (256) clock edges after it is released, `init_busy` is 1. During that time every page reads as unmapped and every configuration command is refused with `cfg_err`. Afterwards `init_busy` is 0 and every page is unmapped until it is configured, including after a reset in the middle of a run.
- R2: The page is selected by `cpu_addr[15:8]` (256 words per page). Every word of a page, from offset 0x00 to 0xFF, follows that page's kind and width.
- R3: An attribute command is `cfg_en`=1 with `cfg_sel`=0, where `cfg_kind` is 0 unmapped, 1 RAM, 2 ROM and 3 reserved, and `cfg_wcode` 0..4 selects 8, 10, 12, 14 or 16 bits. The command is refused, with `cfg_err` high one cycle later and the page left unchanged, if the width code is 5..7, if the kind is reserved, or if it asks for RAM or ROM on a page number of `BACKED_PAGES` (4) or more.
- R4: A read (`cpu_rd`=1) gives `cpu_rvalid`=1 on the next cycle. For a mapped page, `cpu_rdata` then holds the low N bits of the stored word, with the upper bits 0.
- R5: A write (`cpu_wr`=1) to a RAM page stores the low N bits of `cpu_wdata`.
- R6: A read from an unmapped page returns 0xFFFF. A write to an unmapped page changes nothing.
- R7: Processor writes to a ROM page are ignored. A preload (`cfg_en`=1, `cfg_sel`=1) to a ROM page stores `cfg_data` masked to that page's width. A preload to a page that is not ROM is refused with `cfg_err`.
- R8: `cpu_wait` is 0 for every access.
- R9: A read and a RAM write to the same address in the same cycle return the word as it was before the write.
- R10: The read mask follows the page's current width. Narrowing a page hides the upper stored bits, and widening it again shows them.
- R11: When a preload is accepted in the same cycle as a processor RAM write, the preload is stored and the processor write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_rd | input | 1 | Processor read strobe |
| cpu_wr | input | 1 | Processor write strobe |
| cpu_addr | input | 16 | Processor word address |
| cpu_wdata | input | 16 | Processor write data |
| cpu_rdata | output | 16 | Read data, valid with `cpu_rvalid` |
| cpu_rvalid | output | 1 | Read data valid, one cycle after `cpu_rd` |
| cpu_wait | output | 2 | Wait-state count of the returned access |
| cfg_en | input | 1 | Configuration command strobe |
| cfg_sel | input | 1 | 0: page attributes, 1: ROM preload word |
| cfg_addr | input | 16 | Page (upper bits) and word address for the command |
| cfg_kind | input | 2 | Page kind for attribute commands |
| cfg_wcode | input | 3 | Width code for attribute commands |
| cfg_data | input | 16 | Preload data |
| cfg_err | output | 1 | Command of the previous cycle was refused |
| init_busy | output | 1 | Page table sweep in progress |

## Verification
Read-back is tried on pages of four different widths with all-ones data and with mixed data, so a wrong mask shows up as a wrong set of upper bits. The same kind of stimulus is sent to an unmapped page and to a ROM page, so that dropped writes can be told apart from stored ones. Reads and writes that collide on the same address, and preloads that collide with a processor write, check the ordering rules. Narrowing and then widening one page separates masking on read from masking on write. A second reset in the middle of the run shows that the sweep, and not a flop reset, is what unmaps pages the bench had configured.

// File: rtl/mm_pkg.sv
package mm_pkg;

    typedef enum logic [1:0] {
        PG_NONE = 2'd0,
        PG_RAM  = 2'd1,
        PG_ROM  = 2'd2,
        PG_RSVD = 2'd3
    } pg_kind_e;

    typedef struct packed {
        pg_kind_e   kind;
        logic [2:0] wcode;
    } pg_attr_t;

    typedef enum logic {
        ST_CLEAR = 1'b0,
        ST_RUN   = 1'b1
    } sweep_state_e;

    localparam logic [2:0] WCODE_MAX = 3'd4;

endpackage

// File: rtl/mm_width_mask.sv
module mm_width_mask #(
    parameter int DATA_W = 16
) (
    input  logic [2:0]        wcode,
    output logic [DATA_W-1:0] mask
);
    always_comb begin
        for (int b = 0; b < DATA_W; b++) begin
            mask[b] = (b < (8 + 2 * int'(wcode)));
        end
    end
endmodule

// File: rtl/mm_store.sv
module mm_store #(
    parameter int AW     = 10,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              re,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata
);
    localparam int DEPTH = 1 << AW;

    logic [DATA_W-1:0] mem [DEPTH];

    // Both ports are sampled on the same edge, so a colliding read sees the old word.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/mm_page_table.sv
module mm_page_table
    import mm_pkg::*;
#(
    parameter int PIDX_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PIDX_W-1:0] lk_page,
    output pg_attr_t          lk_attr,
    input  logic [PIDX_W-1:0] cf_page,
    output pg_attr_t          cf_attr,
    input  logic              wr_en,
    input  logic [PIDX_W-1:0] wr_page,
    input  pg_attr_t          wr_attr,
    output logic              busy
);
    localparam int PAGES = 1 << PIDX_W;

    pg_attr_t          table_q [PAGES];
    sweep_state_e      state_q, state_d;
    logic [PIDX_W-1:0] clr_cnt_q;
    logic              last_entry;

    assign last_entry = (clr_cnt_q == PIDX_W'(PAGES - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CLEAR: if (last_entry) state_d = ST_RUN;
            ST_RUN:   state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  clr_cnt_q <= '0;
        else if (state_q == ST_CLEAR) clr_cnt_q <= clr_cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (state_q == ST_CLEAR) table_q[clr_cnt_q] <= pg_attr_t'(0);
        else if (wr_en)          table_q[wr_page]   <= wr_attr;
    end

    always_comb begin
        busy    = (state_q == ST_CLEAR);
        lk_attr = busy ? pg_attr_t'(0) : table_q[lk_page];
        cf_attr = busy ? pg_attr_t'(0) : table_q[cf_page];
    end

    p_run_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_RUN |=> state_q == ST_RUN);

    p_sweep_exit_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CLEAR && last_entry) |=> state_q == ST_RUN);
endmodule

// File: rtl/paged_mem_map.sv
module paged_mem_map
    import mm_pkg::*;
#(
    parameter int ADDR_W       = 16,
    parameter int DATA_W       = 16,
    parameter int PAGE_W       = 8,
    parameter int BACKED_PAGES = 4,
    parameter int WAIT_W       = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_rvalid,
    output logic [WAIT_W-1:0] cpu_wait,
    input  logic              cfg_en,
    input  logic              cfg_sel,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [1:0]        cfg_kind,
    input  logic [2:0]        cfg_wcode,
    input  logic [DATA_W-1:0] cfg_data,
    output logic              cfg_err,
    output logic              init_busy
);
    localparam int PIDX_W   = ADDR_W - PAGE_W;
    localparam int BACKED_W = $clog2(BACKED_PAGES);
    localparam int STORE_AW = BACKED_W + PAGE_W;

    logic [PIDX_W-1:0]   cpu_page, cfg_page;
    logic [STORE_AW-1:0] cpu_idx, cfg_idx;
    pg_attr_t            lk_attr, cf_attr, new_attr;
    logic                busy;
    logic                attr_ok, pre_ok, cpu_wr_ok, cfg_reject;
    logic [DATA_W-1:0]   cpu_mask, pre_mask, rd_mask;
    logic                st_we;
    logic [STORE_AW-1:0] st_waddr;
    logic [DATA_W-1:0]   st_wdata, st_rdata;
    pg_kind_e            rkind_q;
    logic [2:0]          rwcode_q;
    logic                rvalid_q, err_q;

    assign cpu_page = cpu_addr[ADDR_W-1:PAGE_W];
    assign cfg_page = cfg_addr[ADDR_W-1:PAGE_W];
    assign cpu_idx  = {cpu_page[BACKED_W-1:0], cpu_addr[PAGE_W-1:0]};
    assign cfg_idx  = {cfg_page[BACKED_W-1:0], cfg_addr[PAGE_W-1:0]};

    mm_page_table #(.PIDX_W(PIDX_W)) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .lk_page (cpu_page),
        .lk_attr (lk_attr),
        .cf_page (cfg_page),
        .cf_attr (cf_attr),
        .wr_en   (attr_ok),
        .wr_page (cfg_page),
        .wr_attr (new_attr),
        .busy    (busy)
    );

    mm_width_mask #(.DATA_W(DATA_W)) u_mask_wr  (.wcode(lk_attr.wcode), .mask(cpu_mask));
    mm_width_mask #(.DATA_W(DATA_W)) u_mask_pre (.wcode(cf_attr.wcode), .mask(pre_mask));
    mm_width_mask #(.DATA_W(DATA_W)) u_mask_rd  (.wcode(rwcode_q),      .mask(rd_mask));

    always_comb begin
        new_attr.kind  = pg_kind_e'(cfg_kind);
        new_attr.wcode = cfg_wcode;
        attr_ok    = cfg_en && !cfg_sel && !busy
                     && (cfg_wcode <= WCODE_MAX)
                     && (new_attr.kind != PG_RSVD)
                     && (new_attr.kind == PG_NONE || cfg_page < PIDX_W'(BACKED_PAGES));
        pre_ok     = cfg_en && cfg_sel && !busy && (cf_attr.kind == PG_ROM);
        cfg_reject = cfg_en && !attr_ok && !pre_ok;
        cpu_wr_ok  = cpu_wr && (lk_attr.kind == PG_RAM) && !pre_ok;
        st_we      = pre_ok || cpu_wr_ok;
        st_waddr   = pre_ok ? cfg_idx : cpu_idx;
        st_wdata   = pre_ok ? (cfg_data & pre_mask) : (cpu_wdata & cpu_mask);
    end

    mm_store #(.AW(STORE_AW), .DATA_W(DATA_W)) u_store (
        .clk   (clk),
        .re    (cpu_rd),
        .raddr (cpu_idx),
        .rdata (st_rdata),
        .we    (st_we),
        .waddr (st_waddr),
        .wdata (st_wdata)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rvalid_q <= 1'b0;
            err_q    <= 1'b0;
            rkind_q  <= PG_NONE;
            rwcode_q <= '0;
        end else begin
            rvalid_q <= cpu_rd;
            err_q    <= cfg_reject;
            if (cpu_rd) begin
                rkind_q  <= lk_attr.kind;
                rwcode_q <= lk_attr.wcode;
            end
        end
    end

    assign cpu_rdata  = (rkind_q == PG_NONE) ? '1 : (st_rdata & rd_mask);
    assign cpu_rvalid = rvalid_q;
    assign cpu_wait   = '0;
    assign cfg_err    = err_q;
    assign init_busy  = busy;

    p_rvalid_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rd |=> cpu_rvalid);

    p_err_needs_cmd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> $past(cfg_en));

    p_unmapped_in_sweep_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rvalid && $past(init_busy)) |-> cpu_rdata == '1);

    p_narrow_upper_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rvalid && rkind_q != PG_NONE && rwcode_q == 3'd0) |-> cpu_rdata[DATA_W-1:8] == '0);
endmodule

// File: tb/paged_mem_map_bench.sv
module paged_mem_map_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NPAGES     = 256;
    localparam int NBACKED    = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_rd = 0, cpu_wr = 0, cfg_en = 0, cfg_sel = 0;
    logic [15:0] cpu_addr = 0, cpu_wdata = 0, cfg_addr = 0, cfg_data = 0;
    logic [1:0]  cfg_kind = 0;
    logic [2:0]  cfg_wcode = 0;
    logic [15:0] cpu_rdata;
    logic        cpu_rvalid, cfg_err, init_busy;
    logic [1:0]  cpu_wait;

    paged_mem_map u_paged_mem_map (
        .clk(clk), .rst_n(rst_n), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .cpu_rvalid(cpu_rvalid), .cpu_wait(cpu_wait), .cfg_en(cfg_en),
        .cfg_sel(cfg_sel), .cfg_addr(cfg_addr), .cfg_kind(cfg_kind),
        .cfg_wcode(cfg_wcode), .cfg_data(cfg_data), .cfg_err(cfg_err),
        .init_busy(init_busy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0, fails = 0;
    string tag = "R1";
    bit finished = 0;

    // Reference model state
    int m_kind [NPAGES];
    int m_wc   [NPAGES];
    int m_mem  [NBACKED*256];
    bit m_busy = 1;
    int m_cnt = 0;
    bit e_valid = 0, e_err = 0;
    int e_rdata = 16'hFFFF;

    function automatic int wmask(int wc);
        return (1 << (8 + 2*wc)) - 1;
    endfunction

    function automatic int midx(logic [15:0] a);
        return (int'(a[15:8]) % NBACKED) * 256 + int'(a[7:0]);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_kind[i]) begin m_kind[i] = 0; m_wc[i] = 0; end
            m_busy = 1; m_cnt = 0; e_valid = 0; e_err = 0; e_rdata = 16'hFFFF;
        end else begin
            int cp, fp;
            bit pre_acc, attr_acc;
            cp = int'(cpu_addr[15:8]);
            fp = int'(cfg_addr[15:8]);
            e_valid = cpu_rd;
            if (cpu_rd)
                e_rdata = (m_kind[cp] == 0) ? 16'hFFFF : (m_mem[midx(cpu_addr)] & wmask(m_wc[cp]));
            pre_acc = 0; attr_acc = 0;
            if (cfg_en && !m_busy) begin
                if (!cfg_sel)
                    attr_acc = (cfg_wcode <= 4) && (cfg_kind != 3) && (cfg_kind == 0 || fp < NBACKED);
                else
                    pre_acc = (m_kind[fp] == 2);
            end
            e_err = cfg_en && !attr_acc && !pre_acc;
            if (cpu_wr && m_kind[cp] == 1 && !pre_acc)
                m_mem[midx(cpu_addr)] = int'(cpu_wdata) & wmask(m_wc[cp]);
            if (pre_acc)
                m_mem[midx(cfg_addr)] = int'(cfg_data) & wmask(m_wc[fp]);
            if (attr_acc) begin
                m_kind[fp] = int'(cfg_kind);
                m_wc[fp]   = int'(cfg_wcode);
            end
            if (m_busy) begin
                m_cnt++;
                if (m_cnt == NPAGES) m_busy = 0;
            end
        end
    end

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Compared on every falling edge against the model.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R1", "init_busy", int'(init_busy), int'(m_busy));
            chk("R4", "cpu_rvalid", int'(cpu_rvalid), int'(e_valid));
            chk(tag, "cfg_err", int'(cfg_err), int'(e_err));
            chk("R8", "cpu_wait", int'(cpu_wait), 0);
            if (e_valid) chk(tag, "cpu_rdata", int'(cpu_rdata), e_rdata);
        end
    end

    task automatic step(bit rd, bit wr, logic [15:0] a, logic [15:0] wd,
                        bit cen, bit csel, logic [15:0] ca, logic [1:0] ck,
                        logic [2:0] cw, logic [15:0] cd);
        cpu_rd = rd; cpu_wr = wr; cpu_addr = a; cpu_wdata = wd;
        cfg_en = cen; cfg_sel = csel; cfg_addr = ca; cfg_kind = ck;
        cfg_wcode = cw; cfg_data = cd;
        @(negedge clk);
    endtask

    task automatic idle();            step(0,0,0,0,0,0,0,0,0,0); endtask
    task automatic rd(logic [15:0] a); step(1,0,a,0,0,0,0,0,0,0); endtask
    task automatic wr(logic [15:0] a, logic [15:0] d); step(0,1,a,d,0,0,0,0,0,0); endtask
    task automatic attr(logic [15:0] a, logic [1:0] k, logic [2:0] w); step(0,0,0,0,1,0,a,k,w,0); endtask
    task automatic pre(logic [15:0] a, logic [15:0] d); step(0,0,0,0,1,1,a,0,0,d); endtask

    task automatic wait_sweep();
        for (int i = 0; i < NPAGES + 2; i++) idle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values seen at the ports
        checks++; if (init_busy !== 1'b1) begin fails++; $display("FAIL R1 reset init_busy: actual %b expected 1", init_busy); end
        checks++; if (cpu_rvalid !== 1'b0) begin fails++; $display("FAIL R1 reset cpu_rvalid: actual %b expected 0", cpu_rvalid); end
        checks++; if (cfg_err !== 1'b0) begin fails++; $display("FAIL R1 reset cfg_err: actual %b expected 0", cfg_err); end
        rst_n = 1'b1;
        tag = "R1";
        attr(16'h0000, 2'd1, 3'd4);
        rd(16'h0005);
        idle();
        wait_sweep();
        rd(16'h0005);
        idle();

        tag = "R3";
        attr(16'h0000, 2'd1, 3'd4);
        attr(16'h0100, 2'd1, 3'd0);
        attr(16'h0200, 2'd2, 3'd2);
        attr(16'h0300, 2'd1, 3'd1);
        attr(16'h0100, 2'd1, 3'd5);
        attr(16'h0100, 2'd3, 3'd0);
        attr(16'h0A00, 2'd1, 3'd4);
        attr(16'h0A00, 2'd0, 3'd0);
        idle();

        tag = "R5";
        wr(16'h0005, 16'hABCD);
        wr(16'h0105, 16'hFFFF);
        wr(16'h0300, 16'h1234);
        tag = "R4";
        rd(16'h0005); rd(16'h0105); rd(16'h0300);
        rd(16'h0A10);
        idle();

        tag = "R2";
        wr(16'h0100, 16'h00A5);
        wr(16'h01FF, 16'h975A);
        rd(16'h0100); rd(16'h01FF);
        idle();

        tag = "R7";
        pre(16'h0210, 16'h2ABC);
        rd(16'h0210);
        wr(16'h0210, 16'h1111);
        rd(16'h0210);
        pre(16'h0007, 16'h3333);
        pre(16'h0A00, 16'h3333);
        rd(16'h0007);
        idle();

        tag = "R6";
        rd(16'h4000);
        wr(16'h4000, 16'h0000);
        rd(16'h4000);
        idle();

        tag = "R9";
        step(1,1,16'h0005,16'h5555,0,0,0,0,0,0);
        rd(16'h0005);
        idle();

        tag = "R10";
        attr(16'h0000, 2'd1, 3'd0);
        rd(16'h0005);
        attr(16'h0000, 2'd1, 3'd4);
        rd(16'h0005);
        idle();

        tag = "R11";
        wr(16'h0006, 16'h7777);
        step(0,1,16'h0006,16'h8888,1,1,16'h0220,0,0,16'hFEDC);
        rd(16'h0006); rd(16'h0220);
        step(0,1,16'h0006,16'h9999,1,1,16'h0006,0,0,16'h4444);
        rd(16'h0006);
        idle();

        tag = "R1";
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        rd(16'h0005);
        idle();
        wait_sweep();
        rd(16'h0005); rd(16'h0210);
        idle();

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule